// File: doc/BRIEF.md
# Bank-Aware DRAM Init and Refresh Command Scheduler

This block is the command front end for an eight-bank, low-latency DRAM with an SRAM-like command set. After reset it runs the power-up sequence on its own. First it issues a set of dummy mode-register writes and one final mode-register write. Then it refreshes every bank once and holds the bus idle for a programmable number of cycles. At the end of this sequence it raises `init_done`.

Once initialization is complete, the block takes read and write requests through a valid/ready port and places each accepted request on the command pins one cycle later. It also keeps one refresh-due flag for each bank. A shared interval timer sets all of these flags together. Due banks are refreshed one command per cycle, and different banks may be refreshed on consecutive cycles.

Every command to a bank (read, write or refresh) starts a row-cycle hold on that bank. No new command to that bank is issued until the hold has run out. Other banks are not affected by it.

Top module: `dram_cmd_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, all three command pins are high (deselect), the bank and address outputs are zero, `init_done` is low and `req_ready` is low.
- R2: The first DUMMY_MRS+1 commands after reset are mode-register writes (all three command pins low) to bank 0. The dummy writes carry address zero. The last write carries MODE_WORD with address bit 10 and every bit above it forced to zero.
- R3: Right after the mode-register writes, exactly one refresh goes to each bank in ascending bank order, on consecutive cycles. Then INIT_NOPS deselect cycles follow. `init_done` rises in the cycle after the last of these and stays high.
- R4: The command pins are encoded as {cs_n, we_n, ref_n}: READ = 011, WRITE = 001, refresh = 010, mode write = 000, and deselect has cs_n = 1 with all pins at 111.
- R5: When `req_valid` and `req_ready` are both high in a cycle, the next cycle shows a READ (`req_write` = 0) or WRITE (`req_write` = 1) with the request's bank on `cmd_ba` and its address on `cmd_addr`.
- R6: After any command to a bank in cycle t, no further command to that bank is issued before cycle t+TRC. A command to another bank may issue in cycle t+1. Deselect cycles do not shorten the hold.
- R7: After initialization, all banks are marked refresh-due at the end of every REF_PERIOD cycles. In a cycle with no accepted request, the lowest-numbered bank that is due and not held gets a refresh (address zero). A refresh clears that bank's due mark.
- R8: A request to a bank that has a refresh due is not accepted until that refresh has issued. A request to a bank with no refresh due that is not held is accepted, even while other banks have refreshes due.
- R9: `req_ready` is low for the whole initialization sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A user request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W (3) | Target bank of the request |
| req_addr | input | ADDR_W (20) | Address of the request |
| req_ready | output | 1 | Request accepted this cycle |
| init_done | output | 1 | Power-up sequence finished |
| cmd_cs_n | output | 1 | Registered chip-select pin, active low |
| cmd_we_n | output | 1 | Registered write-enable pin, active low |
| cmd_ref_n | output | 1 | Registered refresh pin, active low |
| cmd_ba | output | BA_W (3) | Registered bank address |
| cmd_addr | output | ADDR_W (20) | Registered address bus |

## Verification
The hardest case to reach is a request that waits on its own bank's due refresh while that refresh is itself blocked by a row-cycle hold, and all the other banks are in mixed states. The stimulus builds this state by concentrating a dense, back-to-back request stream on two banks just as the interval timer marks every bank due. It also keeps a held request presented until it is accepted. A behavioural model tracks, for each bank, the cycle of its last command and its due mark. That model predicts `req_ready` and every pin on every cycle, so any ordering slip between refreshes and requests shows up at once.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
    typedef enum logic [2:0] {CMD_NOP, CMD_MRS, CMD_RD, CMD_WR, CMD_AREF} cmd_e;

    // returns {cs_n, we_n, ref_n}
    function automatic logic [2:0] cmd_pins(cmd_e c);
        case (c)
            CMD_MRS:  return 3'b000;
            CMD_RD:   return 3'b011;
            CMD_WR:   return 3'b001;
            CMD_AREF: return 3'b010;
            default:  return 3'b111;
        endcase
    endfunction
endpackage

// File: rtl/dram_bank_trk.sv
module dram_bank_trk #(
    parameter int TRC = 4,
    localparam int TRC_W = $clog2(TRC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic set_due,
    input  logic clr_due,
    output logic busy,
    output logic due
);
    localparam logic [TRC_W-1:0] HOLD = TRC_W'(TRC - 1);

    typedef struct packed {
        logic [TRC_W-1:0] cnt;
        logic             due;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (issue)
            st_d.cnt = HOLD;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - TRC_W'(1);
        if (set_due)
            st_d.due = 1'b1;
        else if (clr_due)
            st_d.due = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);
    assign due  = st_q.due;

    // R6: the scheduler never targets a bank still inside its row-cycle hold
    a_r6_issue_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (st_q.cnt == '0));
    // R7: a due mark survives until its refresh is issued
    a_r7_due_held: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !clr_due) |=> due);
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_sched_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 20,
    parameter int DUMMY_MRS = 2,
    parameter int INIT_NOPS = 1024,
    parameter int MRS_KEEP  = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              done,
    output cmd_e              cmd,
    output logic [BA_W-1:0]   bank,
    output logic [ADDR_W-1:0] addr
);
    localparam int CNT_MAX0 = (DUMMY_MRS > NUM_BANKS) ? DUMMY_MRS : NUM_BANKS;
    localparam int CNT_MAX  = (INIT_NOPS > CNT_MAX0) ? INIT_NOPS : CNT_MAX0;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LAST_MRS  = CNT_W'(DUMMY_MRS);
    localparam logic [CNT_W-1:0] LAST_BANK = CNT_W'(NUM_BANKS - 1);
    localparam logic [CNT_W-1:0] LAST_NOP  = CNT_W'(INIT_NOPS - 1);
    localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'((64'd1 << MRS_KEEP) - 64'd1);

    typedef enum logic [1:0] {PH_MRS, PH_AREF, PH_NOP, PH_DONE} phase_e;
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        cmd  = CMD_NOP;
        bank = '0;
        addr = '0;
        case (st_q.ph)
            PH_MRS: begin
                cmd = CMD_MRS;
                if (st_q.cnt == LAST_MRS) begin
                    addr     = MODE_WORD & KEEP_MASK;
                    st_d.ph  = PH_AREF;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_AREF: begin
                cmd  = CMD_AREF;
                bank = st_q.cnt[BA_W-1:0];
                if (st_q.cnt == LAST_BANK) begin
                    st_d.ph  = PH_NOP;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_NOP: begin
                if (st_q.cnt == LAST_NOP) begin
                    st_d.ph  = PH_DONE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            default: done = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_MRS, cnt: '0};
        else        st_q <= st_d;
    end

    // R3: once finished, the sequence never restarts
    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    // R2: the mode-register phase only ever emits mode writes
    a_r2_mrs_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_MRS) |-> (cmd == CMD_MRS));
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
    import dram_sched_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int ADDR_W     = 20,
    parameter int TRC        = 4,
    parameter int REF_PERIOD = 780,
    parameter int DUMMY_MRS  = 2,
    parameter int INIT_NOPS  = 1024,
    parameter logic [ADDR_W-1:0] MODE_WORD = 20'h0_0021,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              init_done,
    output logic              cmd_cs_n,
    output logic              cmd_we_n,
    output logic              cmd_ref_n,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int RP_W = $clog2(REF_PERIOD);
    localparam logic [RP_W-1:0] RP_LAST = RP_W'(REF_PERIOD - 1);

    typedef struct packed {
        logic              cs_n;
        logic              we_n;
        logic              ref_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic [RP_W-1:0]   tmr;
    } top_t;

    top_t st_d, st_q;

    cmd_e              init_cmd, cmd;
    logic [BA_W-1:0]   init_bank, nba;
    logic [ADDR_W-1:0] init_addr, naddr;
    logic [NUM_BANKS-1:0] busy, due, issue_v, clr_v;
    logic              set_due, found;

    dram_init_seq #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DUMMY_MRS(DUMMY_MRS),
        .INIT_NOPS(INIT_NOPS), .MRS_KEEP(10), .MODE_WORD(MODE_WORD)
    ) u_init (
        .clk(clk), .rst_n(rst_n), .done(init_done),
        .cmd(init_cmd), .bank(init_bank), .addr(init_addr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dram_bank_trk #(.TRC(TRC)) u_trk (
            .clk(clk), .rst_n(rst_n), .issue(issue_v[b]),
            .set_due(set_due), .clr_due(clr_v[b]),
            .busy(busy[b]), .due(due[b])
        );
    end

    always_comb begin
        st_d      = st_q;
        issue_v   = '0;
        clr_v     = '0;
        set_due   = 1'b0;
        req_ready = 1'b0;
        found     = 1'b0;
        cmd       = CMD_NOP;
        nba       = '0;
        naddr     = '0;
        if (!init_done) begin
            cmd   = init_cmd;
            nba   = init_bank;
            naddr = init_addr;
            if (init_cmd == CMD_AREF) issue_v[init_bank] = 1'b1;
        end else begin
            if (st_q.tmr == RP_LAST) begin
                st_d.tmr = '0;
                set_due  = 1'b1;
            end else begin
                st_d.tmr = st_q.tmr + RP_W'(1);
            end
            if (req_valid && !busy[req_bank] && !due[req_bank]) begin
                req_ready         = 1'b1;
                cmd               = req_write ? CMD_WR : CMD_RD;
                nba               = req_bank;
                naddr             = req_addr;
                issue_v[req_bank] = 1'b1;
            end else begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (!found && due[b] && !busy[b]) begin
                        found      = 1'b1;
                        cmd        = CMD_AREF;
                        nba        = BA_W'(b);
                        issue_v[b] = 1'b1;
                        clr_v[b]   = 1'b1;
                    end
                end
            end
        end
        {st_d.cs_n, st_d.we_n, st_d.ref_n} = cmd_pins(cmd);
        st_d.ba   = nba;
        st_d.addr = naddr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cs_n: 1'b1, we_n: 1'b1, ref_n: 1'b1, ba: '0, addr: '0, tmr: '0};
        else        st_q <= st_d;
    end

    assign cmd_cs_n  = st_q.cs_n;
    assign cmd_we_n  = st_q.we_n;
    assign cmd_ref_n = st_q.ref_n;
    assign cmd_ba    = st_q.ba;
    assign cmd_addr  = st_q.addr;

    // R9: no request is taken before the power-up sequence ends
    a_r9_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);
    // R5: an accepted request reaches the pins one cycle later with its bank
    a_r5_req_to_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!cmd_cs_n && cmd_ref_n && cmd_ba == $past(req_bank)));
    // R6: two refreshes in a row never hit the same bank
    a_r6_aref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_cs_n && cmd_we_n && !cmd_ref_n) |=>
        !(!cmd_cs_n && cmd_we_n && !cmd_ref_n && cmd_ba == $past(cmd_ba)));
endmodule

// File: tb/dram_cmd_sched_tb.sv
module dram_cmd_sched_tb;
    localparam int NB    = 8;
    localparam int AW    = 20;
    localparam int TRC   = 5;
    localparam int RP    = 40;
    localparam int DUMMY = 2;
    localparam int NOPS  = 24;
    localparam logic [AW-1:0] MODE = 20'hFA53C;
    localparam int TOTAL = DUMMY + 1 + NB + NOPS;
    localparam int RUN_CYCLES = 1500;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]    req_bank = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, init_done, cmd_cs_n, cmd_we_n, cmd_ref_n;
    logic [2:0]    cmd_ba;
    logic [AW-1:0] cmd_addr;

    always #2 clk = ~clk;

    dram_cmd_sched #(
        .NUM_BANKS(NB), .ADDR_W(AW), .TRC(TRC), .REF_PERIOD(RP),
        .DUMMY_MRS(DUMMY), .INIT_NOPS(NOPS), .MODE_WORD(MODE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_addr(req_addr), .req_ready(req_ready),
        .init_done(init_done), .cmd_cs_n(cmd_cs_n), .cmd_we_n(cmd_we_n),
        .cmd_ref_n(cmd_ref_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model state
    int   last_cmd[NB];
    bit   due_m[NB];
    int   cyc;
    logic [2:0]    e_pins;
    logic [2:0]    e_ba;
    logic [AW-1:0] e_addr;
    string         e_tag;

    initial begin
        int   kind;          // 0 NOP 1 MRS 2 RD 3 WR 4 AREF
        int   k_bank;
        logic [AW-1:0] k_addr;
        bit   e_ready, accepted, set_now;
        string r_tag, k_tag;
        for (int b = 0; b < NB; b++) begin last_cmd[b] = -1000; due_m[b] = 0; end
        accepted = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pins", {61'd0, cmd_cs_n, cmd_we_n, cmd_ref_n}, 64'd7);
        check("R1 ba/addr", {41'd0, cmd_ba, cmd_addr}, 64'd0);
        check("R1 init_done", {63'd0, init_done}, 64'd0);
        check("R1 req_ready", {63'd0, req_ready}, 64'd0);
        rst_n = 1'b1;
        e_pins = 3'b111; e_ba = '0; e_addr = '0; e_tag = "R1 first cycle";
        for (cyc = 0; cyc < TOTAL + RUN_CYCLES; cyc++) begin
            // drive request for this cycle
            if (!req_valid || accepted) begin
                int rc = cyc - TOTAL;
                if (rc < 500)       req_valid = ($urandom_range(9, 0) < 6);
                else if (rc < 1000) req_valid = ($urandom_range(9, 0) < 8);
                else                req_valid = 1'b1;
                if (rc >= 500 && rc < 1000) req_bank = 3'($urandom_range(3, 2));
                else if (rc >= 1000)        req_bank = 3'd5;
                else                        req_bank = 3'($urandom_range(7, 0));
                req_write = 1'($urandom_range(1, 0));
                req_addr  = AW'($urandom);
            end
            #1;
            // model decision
            kind = 0; k_bank = 0; k_addr = '0; e_ready = 1'b0; set_now = 1'b0;
            k_tag = "R6 run NOP"; r_tag = "R5 ready";
            if (cyc < TOTAL) begin
                r_tag = "R9 ready during init";
                if (cyc <= DUMMY) begin
                    kind = 1; k_tag = "R2 mode write";
                    if (cyc == DUMMY) k_addr = MODE & AW'(20'h003FF);
                end else if (cyc < DUMMY + 1 + NB) begin
                    kind = 4; k_bank = cyc - DUMMY - 1; k_tag = "R3 init refresh";
                end else begin
                    k_tag = "R3 init deselect";
                end
            end else begin
                set_now = (((cyc - TOTAL) % RP) == RP - 1);
                if (req_valid) begin
                    if (cyc - last_cmd[req_bank] < TRC) r_tag = "R6 ready held bank";
                    else if (due_m[req_bank])           r_tag = "R8 ready due bank";
                end
                if (req_valid && (cyc - last_cmd[req_bank] >= TRC) && !due_m[req_bank]) begin
                    e_ready = 1'b1;
                    kind = req_write ? 3 : 2; k_bank = req_bank; k_addr = req_addr;
                    k_tag = "R5 request";
                end else begin
                    for (int b = NB - 1; b >= 0; b--)
                        if (due_m[b] && (cyc - last_cmd[b] >= TRC)) begin
                            kind = 4; k_bank = b;
                        end
                    if (kind == 4) k_tag = "R7 refresh";
                end
            end
            check("R3 init_done", {63'd0, init_done}, {63'd0, (cyc >= TOTAL)});
            check(r_tag, {63'd0, req_ready}, {63'd0, e_ready});
            @(posedge clk);
            // apply
            accepted = e_ready;
            case (kind)
                1: e_pins = 3'b000;
                2: e_pins = 3'b011;
                3: e_pins = 3'b001;
                4: e_pins = 3'b010;
                default: e_pins = 3'b111;
            endcase
            e_ba = 3'(k_bank); e_addr = k_addr; e_tag = k_tag;
            if (kind >= 2 || (kind == 4)) last_cmd[k_bank] = cyc;
            if (kind == 4 && cyc >= TOTAL) due_m[k_bank] = 0;
            if (set_now) for (int b = 0; b < NB; b++) due_m[b] = 1;
            @(negedge clk);
            check({e_tag, " R4 pins"}, {61'd0, cmd_cs_n, cmd_we_n, cmd_ref_n}, {61'd0, e_pins});
            check({e_tag, " bank"}, {61'd0, cmd_ba}, {61'd0, e_ba});
            check({e_tag, " addr"}, {44'd0, cmd_addr}, {44'd0, e_addr});
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule